// File: doc/BRIEF.md
# Clock Output Configuration Selector and Sequencer

This block is the digital control path of a multi-output clock generator. It works from one reference clock. A 3-bit select input chooses one of eight stored configuration words. The chosen word sets a divide ratio for each of two output banks and an enable bit for each of nine outputs. Bank A drives four outputs and bank B drives four more. Each bank's outputs are taken from a single divider counter, so they switch on the same reference edge. A ninth output runs at half the reference rate.

An active-low power-down input stops the block and releases every output. A change on the select input has the same effect as a short power-down followed by a restart. Every restart, whether it comes from reset, from power-down release or from a select change, first runs a fixed test window on one output and then starts the normal divided clocks. The configuration words are loaded through a simple synchronous write port.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset, the select synchronizer and the stored index are all ones, so index 7 applies until the select input changes. Each of the eight entries is chosen by `sel_i` once the change has passed the synchronizer and the restart.
- R2: While the block is off, `clk_oe_o` and `clk_o` are all zero. This holds during reset and from the first edge that samples `pwr_n_i` low.
- R3: A divide field below 2 acts as 2, and a divide field above 20 acts as 20. Values from 2 through 20 are used as written.
- R4: A bank with divide D has a period of D reference cycles. Its output is high for floor(D/2) cycles and low for the rest, so for odd D the high time is one cycle shorter than the low time. The output starts high on the first run cycle.
- R5: All enabled outputs of one bank carry identical values in every cycle.
- R6: In run, an output whose enable bit is clear is driven low with `clk_oe_o` high.
- R7: Each start runs a test window of exactly 170 cycles. In that window `clk_o[6]` is high in the window's even cycles (counting from 0) and low in its odd cycles. Every other output is low, and all outputs are driven.
- R8: `sel_i` passes through two flops. A change seen after them forces one off cycle and then a new test window. If `sel_i` changes just before edge S+1, the block is off in cycle S+3, tests from S+4 and runs from S+174.
- R9: `clk_o[8]` toggles every run cycle, starting high, when enable bit 8 is set.
- R10: When `cfg_we_i` is high at an edge, the word on `cfg_wdata_i` is stored at `cfg_addr_i`. Bits [4:0] hold the bank A divide and bits [9:5] the bank B divide. Bits [18:10] hold the enables, with bit 10+i gating `clk_o[i]`. Outputs 0 to 3 belong to bank A, outputs 4 to 7 to bank B, and output 8 is the extra output.
- R11: After reset release, or when `pwr_n_i` rises, the test window starts on the next edge and run begins 170 cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Configuration select |
| pwr_n_i | input | 1 | Power-down, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration write index |
| cfg_wdata_i | input | 19 | Configuration word |
| clk_o | output | 9 | Clock outputs (low when released) |
| clk_oe_o | output | 9 | Output drive enables |

## Verification
The time at which each result is due is counted from the edge that follows the stimulus. Power-down takes effect one cycle later. A select change shows as an off cycle three cycles later. The test window then starts on the next cycle, and run begins 170 cycles after the window starts. A release of reset or power-down starts the test window one cycle later. The driver stamps every expected value with the absolute cycle number derived from these latencies. The monitor compares each value in exactly that cycle and samples on the falling edge. The driver leaves out the two cycles a select change spends inside the synchronizer.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NCFG     = 8;
  localparam int SEL_W    = $clog2(NCFG);
  localparam int DIV_W    = 5;
  localparam int DIV_MIN  = 2;
  localparam int DIV_MAX  = 20;
  localparam int BANK_N   = 4;
  localparam int NBANK    = 2;
  localparam int NOUT     = NBANK * BANK_N + 1;
  localparam int CFG_W    = 2 * DIV_W + NOUT;
  localparam int TEST_LEN = 170;
  localparam int TEST_OUT = 6;
  localparam int TCNT_W   = $clog2(TEST_LEN);

  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_TEST = 2'd1, ST_RUN = 2'd2} seq_st_t;

  typedef struct packed {
    logic [NOUT-1:0]  en;
    logic [DIV_W-1:0] div_b;
    logic [DIV_W-1:0] div_a;
  } cfg_t;

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    if (d < DIV_W'(DIV_MIN))      return DIV_W'(DIV_MIN);
    else if (d > DIV_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
    else                          return d;
  endfunction
endpackage

// File: rtl/sel_sync.sv
module sel_sync
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_cur_o,
  output logic             sel_chg_o
);
  logic [SEL_W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= sel_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign sel_chg_o = (s2_q != prev_q);
  assign sel_cur_o = prev_q;

  // R8
  sync_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg_o |=> (sel_cur_o == $past(s2_q)));
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] raddr_i,
  output cfg_t             rdata_o
);
  cfg_t mem_q [NCFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= cfg_t'(wdata_i);
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R10
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == raddr_i) |=> ($past(raddr_i) != raddr_i || rdata_o == $past(wdata_i)));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_n_i,
  input  logic    sel_chg_i,
  output seq_st_t st_o,
  output logic    test_bit_o,
  output logic    test_done_o
);
  seq_st_t           st_q;
  logic [TCNT_W-1:0] tcnt_q;

  assign test_done_o = (st_q == ST_TEST) && (tcnt_q == TCNT_W'(TEST_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      tcnt_q <= '0;
    end else if (!pwr_n_i || sel_chg_i) begin
      st_q   <= ST_OFF;
      tcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_q   <= ST_TEST;
          tcnt_q <= '0;
        end
        ST_TEST: begin
          if (test_done_o) st_q <= ST_RUN;
          else tcnt_q <= tcnt_q + 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign st_o       = st_q;
  assign test_bit_o = (st_q == ST_TEST) && !tcnt_q[0];

  // R2
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n_i |=> (st_o == ST_OFF));
  // R8
  sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_chg_i && pwr_n_i) |=> (st_o == ST_OFF) ##1 (!$past(pwr_n_i) || $past(sel_chg_i) || st_o == ST_TEST));
  // R7
  test_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done_o && pwr_n_i && !sel_chg_i) |=> (st_o == ST_RUN));
  // R11
  off_to_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == ST_OFF && pwr_n_i && !sel_chg_i) |=> (st_o == ST_TEST && test_bit_o));
endmodule

// File: rtl/bank_div.sv
module bank_div
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             hi_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run_i)               cnt_q <= '0;
    else if (cnt_q >= div_i - 1'b1) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign hi_o = run_i && (cnt_q < (div_i >> 1));

  // R4
  div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (div_i >= DIV_W'(DIV_MIN) && div_i <= DIV_W'(DIV_MAX)));
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel_i,
  input  logic             pwr_n_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [18:0]      cfg_wdata_i,
  output logic [8:0]       clk_o,
  output logic [8:0]       clk_oe_o
);
  logic [SEL_W-1:0] sel_cur;
  logic             sel_chg;
  cfg_t             cfg;
  seq_st_t          st;
  logic             test_bit, test_done;
  logic [NBANK-1:0] bank_hi;
  logic [DIV_W-1:0] div_eff [NBANK];
  logic             run_on, x_q;

  sel_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
    .sel_cur_o(sel_cur), .sel_chg_o(sel_chg)
  );

  cfg_store u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .raddr_i(sel_cur), .rdata_o(cfg)
  );

  startup_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_n_i(pwr_n_i), .sel_chg_i(sel_chg),
    .st_o(st), .test_bit_o(test_bit), .test_done_o(test_done)
  );

  assign run_on     = (st == ST_RUN);
  assign div_eff[0] = clamp_div(cfg.div_a);
  assign div_eff[1] = clamp_div(cfg.div_b);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_div u_div (
      .clk(clk), .rst_n(rst_n), .run_i(run_on),
      .div_i(div_eff[b]), .hi_o(bank_hi[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       x_q <= 1'b1;
    else if (!run_on) x_q <= 1'b1;
    else              x_q <= ~x_q;
  end

  always_comb begin
    clk_o    = '0;
    clk_oe_o = (st == ST_OFF) ? '0 : '1;
    if (st == ST_TEST) begin
      clk_o[TEST_OUT] = test_bit;
    end else if (run_on) begin
      for (int i = 0; i < BANK_N; i++) begin
        clk_o[i]          = cfg.en[i] & bank_hi[0];
        clk_o[BANK_N + i] = cfg.en[BANK_N + i] & bank_hi[1];
      end
      clk_o[NOUT-1] = cfg.en[NOUT-1] & x_q;
    end
  end

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe_o == '0) |-> (clk_o == '0));
  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_on |-> ((clk_o & ~cfg.en) == '0 && clk_oe_o == '1));
  // R9
  extra_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_on && $past(run_on) && cfg.en[NOUT-1] && $stable(cfg.en)) |-> (clk_o[NOUT-1] != $past(clk_o[NOUT-1])));
  // R7
  test_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TEST) |-> ($countones(clk_o) <= 1 && (clk_o & ~(9'b1 << TEST_OUT)) == '0));
  // R5
  bank_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_on && cfg.en[1:0] == 2'b11) |-> (clk_o[0] == clk_o[1]));
endmodule

// File: tb/sim_clkgen_ctrl.sv
module sim_clkgen_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel_i;
  logic        pwr_n_i;
  logic        cfg_we_i;
  logic [2:0]  cfg_addr_i;
  logic [18:0] cfg_wdata_i;
  logic [8:0]  clk_o, clk_oe_o;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [8:0] val;
    logic [8:0] oe;
    string      tag;
  } exp_t;
  exp_t q[$];

  clkgen_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .pwr_n_i(pwr_n_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .clk_o(clk_o), .clk_oe_o(clk_oe_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expectation in its own cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.at != cyc || clk_o !== e.val || clk_oe_o !== e.oe) begin
        n_err++;
        $display("FAIL %s cyc=%0d: clk_o=%b oe=%b, expected clk_o=%b oe=%b (due %0d)",
                 e.tag, cyc, clk_o, clk_oe_o, e.val, e.oe, e.at);
      end
    end
  end

  task automatic push(input int at, input logic [8:0] v, input logic [8:0] oe, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.oe = oe; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int eff_div(input int d);
    if (d < 2) return 2;
    if (d > 20) return 20;
    return d;
  endfunction

  // expected run value r cycles after run began
  function automatic logic [8:0] run_val(input int r, input int da, input int db, input logic [8:0] en);
    logic [8:0] v;
    bit ha, hb;
    ha = (r % da) < (da / 2);
    hb = (r % db) < (db / 2);
    for (int i = 0; i < 9; i++) v[i] = (i < 4) ? ha : (i < 8) ? hb : (r % 2 == 0);
    return v & en;
  endfunction

  task automatic exp_test(input int start, input string tag);
    for (int k = 0; k < 170; k++)
      push(start + k, (k % 2 == 0) ? 9'h040 : 9'h000, 9'h1FF, tag);
  endtask

  task automatic exp_run(input int start, input int n, input int da, input int db,
                         input logic [8:0] en, input string tag);
    for (int r = 0; r < n; r++)
      push(start + r, run_val(r, eff_div(da), eff_div(db), en), 9'h1FF, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [8:0] en, input logic [4:0] db, input logic [4:0] da);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = {en, db, da};
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    int r0, s0, p0, q0;
    rst_n = 1'b0; sel_i = 3'd7; pwr_n_i = 1'b1;
    cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    @(negedge clk);
    push(cyc + 1, 9'h000, 9'h000, "R2 reset");
    repeat (3) @(negedge clk);

    // release reset: test window next edge, index 7 by default
    r0 = cyc;
    rst_n = 1'b1;
    exp_test(r0 + 1, "R7/R11 reset start");
    wr(3'd7, 9'h1FF, 5'd4, 5'd3);
    wr(3'd2, 9'b1_0011_1010, 5'd25, 5'd1);
    wr(3'd5, 9'h1FF, 5'd2, 5'd5);
    // R1 R4 R5 R9 R10: index 7, odd A=3, even B=4
    exp_run(r0 + 171, 24, 3, 4, 9'h1FF, "R1/R4/R9 cfg7");
    wait_cyc(r0 + 194);

    // R8 select change to 2; R3 clamps; R6 disabled outputs low
    @(negedge clk);
    s0 = cyc;
    sel_i = 3'd2;
    push(s0 + 3, 9'h000, 9'h000, "R8 off cycle");
    exp_test(s0 + 4, "R8/R7 restart");
    exp_run(s0 + 174, 44, 1, 25, 9'b1_0011_1010, "R3/R6/R1 cfg2");
    wait_cyc(s0 + 217);

    // R2 power-down, select moves to 5 while off
    @(negedge clk);
    q0 = cyc;
    pwr_n_i = 1'b0;
    for (int k = 1; k <= 8; k++) push(q0 + k, 9'h000, 9'h000, "R2 power-down");
    @(negedge clk);
    sel_i = 3'd5;
    wait_cyc(q0 + 8);

    // R11 power-up; R4 odd A=5, B=2
    p0 = cyc;
    pwr_n_i = 1'b1;
    exp_test(p0 + 1, "R11/R7 power-up");
    exp_run(p0 + 171, 30, 5, 2, 9'h1FF, "R4/R5/R11 cfg5");
    wait_cyc(p0 + 205);

    if (q.size() != 0) begin
      n_err++;
      $display("FAIL R7 %0d expectations not consumed, expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end
endmodule